// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital search engine of a successive-approximation analog-to-digital converter. It presents a trial code to an external DAC, reads back one comparator bit that reports whether the DAC level lies at or below the analog input, and settles one result bit per clock. The search runs from the most significant bit down to the least significant one. An N-bit conversion therefore always takes N clock periods, whatever the input.

A conversion is requested by pulling the active-low start line from high to low. The block first offers half of full scale. On each later clock it keeps or drops the bit under test and raises the next lower bit. After the last decision it raises a one-cycle completion pulse and latches the code into a result register. That register holds its value until the next conversion completes. The start line acts on its falling transition only: a line that stays low does nothing more, and a falling transition during a search is ignored. The result is a plain registered output qualified by the done pulse. There is no back-pressure: whoever needs the code takes it at the pulse or later, before the next completion.

Top module: `sar_ctrl`

## Requirements
- R1: After reset, trial and result are all zeros, and busy and done are low.
- R2: A conversion is launched only by a high-to-low transition of start_n seen at a rising clock edge while idle. A low level held through reset, or held after a completion, launches nothing.
- R3: The launching edge sets trial to a code with only the MSB set (half scale) and raises busy.
- R4: On each following edge, cmp_hi is sampled for the bit under test. 1 (DAC at or below input) keeps that bit and 0 clears it, and the next lower bit is set to 1. After k decisions on an input equal to code v, trial equals the top k bits of v with bit WIDTH-1-k set.
- R5: done is high for exactly one cycle, WIDTH clock edges after the launching edge. busy falls on the same edge.
- R6: result takes the final code on the done edge (the top bits plus the LSB decision). Trial also shows that code, and result holds it unchanged until the next completion.
- R7: A falling transition of start_n while a conversion runs is ignored. The search continues and finishes at its normal time with the normal code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low start request, acts on its falling transition |
| cmp_hi | input | 1 | Comparator: 1 when the DAC level is at or below the input |
| trial | output | WIDTH | Code presented to the DAC |
| busy | output | 1 | High while a search is running |
| done | output | 1 | One-cycle pulse when the result is ready |
| result | output | WIDTH | Last completed conversion code |

## Verification
The bench targets the extreme codes all zeros and all ones, the codes on either side of mid scale, and an irregular pattern. A design that set the next bit before clearing the failed one, or that read the comparator a cycle late, would give a wrong trial sequence or a wrong final code on these inputs. It holds start low through reset and after completion. A level-triggered start would then run conversions back to back, and the bench would see busy or extra done pulses. A falling start edge placed mid-search catches a design that restarts: its done would come late and its trial sequence would jump back to half scale.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_SEARCH = 1'b1
  } sar_phase_e;
endpackage

// File: rtl/sar_start_gate.sv
module sar_start_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic start_n,
  input  logic idle,
  output logic launch
);
  // Resets to "seen low" so a line held low through reset does not launch.
  logic start_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_prev <= 1'b0;
    else        start_prev <= start_n;
  end

  assign launch = start_prev & ~start_n & idle;
endmodule

// File: rtl/sar_bit_seq.sv
module sar_bit_seq #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  output logic [WIDTH-1:0] ptr,
  output logic             busy,
  output logic             last
);
  import sar_pkg::*;

  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  sar_phase_e phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      ptr   <= '0;
    end else if (phase == PH_IDLE) begin
      if (launch) begin
        phase <= PH_SEARCH;
        ptr   <= TOP_BIT;
      end
    end else begin
      ptr <= ptr >> 1;
      if (ptr[0]) phase <= PH_IDLE;
    end
  end

  assign busy = (phase == PH_SEARCH);
  assign last = busy & ptr[0];
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [WIDTH-1:0] ptr,
  input  logic             last,
  input  logic             cmp_hi,
  output logic [WIDTH-1:0] trial,
  output logic [WIDTH-1:0] result
);
  logic [WIDTH-1:0] trial_nxt;

  // Per-bit update: decide the bit under test, raise the one just below it.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == WIDTH - 1) begin : g_top
      always_comb begin
        if (launch)      trial_nxt[i] = 1'b1;
        else if (ptr[i]) trial_nxt[i] = cmp_hi;
        else             trial_nxt[i] = trial[i];
      end
    end else begin : g_low
      always_comb begin
        if (launch)        trial_nxt[i] = 1'b0;
        else if (ptr[i])   trial_nxt[i] = cmp_hi;
        else if (ptr[i+1]) trial_nxt[i] = 1'b1;
        else               trial_nxt[i] = trial[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial  <= '0;
      result <= '0;
    end else begin
      trial <= trial_nxt;
      if (last) result <= {trial[WIDTH-1:1], cmp_hi};
    end
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_n,
  input  logic             cmp_hi,
  output logic [WIDTH-1:0] trial,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  logic             launch;
  logic             last;
  logic [WIDTH-1:0] ptr;

  sar_start_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_n(start_n),
    .idle   (~busy),
    .launch (launch)
  );

  sar_bit_seq #(.WIDTH(WIDTH)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .launch(launch),
    .ptr   (ptr),
    .busy  (busy),
    .last  (last)
  );

  sar_code_reg #(.WIDTH(WIDTH)) u_code (
    .clk   (clk),
    .rst_n (rst_n),
    .launch(launch),
    .ptr   (ptr),
    .last  (last),
    .cmp_hi(cmp_hi),
    .trial (trial),
    .result(result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= last;
  end
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] trial,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result
);
  localparam logic [WIDTH-1:0] HALF = {1'b1, {(WIDTH-1){1'b0}}};

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r3_half_scale: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> trial == HALF);

  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> trial != HALF);

  a_r6_trial_matches: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> trial == result);
endmodule

bind sar_ctrl sar_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .trial (trial),
  .busy  (busy),
  .done  (done),
  .result(result)
);

// File: tb/sim_sar_ctrl.sv
`timescale 1ns/1ps
module sim_sar_ctrl;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_n = 1'b0;
  logic [W-1:0] vin = '0;
  logic [W-1:0] trial, result;
  logic         busy, done, cmp_hi;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];

  always #10 clk = ~clk;

  // Behavioural DAC and comparator: DAC level = trial, input sits half an LSB above vin.
  assign cmp_hi = (trial <= vin);

  sar_ctrl #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .cmp_hi(cmp_hi),
    .trial(trial), .busy(busy), .done(done), .result(result)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_trial(input int v, input int k);
    int upper = ((1 << W) - 1) ^ ((1 << (W - k)) - 1);
    return (v & upper) | (1 << (W - 1 - k));
  endfunction

  // Monitor: pops the scoreboard on every done pulse.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) check("R5 unexpected done", 1, 0);
      else check("R6 result", int'(result), int'(exp_q.pop_front()));
    end
  end

  // Driver: one conversion; glitch adds a falling start edge mid-search.
  task automatic convert(input int v, input bit glitch);
    @(negedge clk);
    vin = W'(v);
    exp_q.push_back(W'(v));
    start_n = 1'b0;
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      if (k == 0) check("R3 busy", int'(busy), 1);
      check(k == 0 ? "R3 half scale" : (glitch ? "R7 trial" : "R4 trial"),
            int'(trial), exp_trial(v, k));
      check("R5 no early done", int'(done), 0);
      if (glitch && k == 2) start_n = 1'b1;
      if (glitch && k == 4) start_n = 1'b0;
    end
    @(negedge clk);
    check("R5 done on time", int'(done), 1);
    check("R5 busy low", int'(busy), 0);
    check("R6 trial final", int'(trial), v);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      check("R2 held low no relaunch", int'(busy | done), 0);
      check("R6 result held", int'(result), v);
    end
    start_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 trial", int'(trial), 0);
    check("R1 result", int'(result), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 low after reset", int'(busy), 0);
    check("R2 trial idle", int'(trial), 0);
    start_n = 1'b1;
    @(negedge clk);
    convert(8'hB7, 1'b0);
    convert(8'h00, 1'b0);
    convert(8'hFF, 1'b0);
    convert(8'h80, 1'b0);
    convert(8'h7F, 1'b0);
    convert(8'h01, 1'b0);
    convert(8'h5A, 1'b1);
    convert(8'hC3, 1'b0);
    repeat (2) @(negedge clk);
    check("R5 scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule